// File: doc/BRIEF.md
# Camera Pixel Byte Packer

This block sits on the receive side of a parallel 8-bit image sensor interface. Each pixel reaches it as two bytes on successive clocks, and only while the sensor's line-valid strobe is high. An internal phase flag flips on every captured byte. The first byte of each pair is held as the upper half of a 16-bit word. The second byte completes the word, and the same flag phase writes the word into a small local FIFO. A downstream memory controller drains that FIFO in bursts and uses the fill count to decide when to start a transfer. A 640-pixel line therefore produces 640 words.

The phase flag returns to its starting value whenever the line strobe is low, so a stray odd byte at the end of a line cannot misalign the next line. The FIFO is synchronous: one clock drives both its write and read sides, and its read data falls through, meaning the oldest word is on the output whenever the FIFO is not empty. A word that completes while the FIFO is full is discarded and sets a sticky overflow flag. The block also detects the rising edge of the frame strobe and outputs a one-cycle frame-start pulse, which downstream logic uses to reset its write addresses.

Top module: `cam_byte_packer`

## Requirements
- R1: While reset is high, and on the first cycle after it is released, `fill_o` is 0, `overflow_o` is 0 and `frame_start_o` is 0.
- R2: In a line, the first captured byte goes to bits 15:8 and the second to bits 7:0 of the same word. The word is written on the clock edge that captures the second byte, and `fill_o` rises by one after that edge.
- R3: A byte presented while `line_valid_i` is low is not captured and does not change `fill_o` or the data that is later read.
- R4: When `line_valid_i` is low at a clock edge, the pairing restarts. A lone unpaired byte left from the previous line is discarded, and the next captured byte becomes the upper half of a new word.
- R5: Words leave the FIFO in the order they were written. Whenever `fill_o` is nonzero, `rd_data_o` shows the oldest stored word. `rd_en_i` high at an edge removes that word, and `fill_o` falls by one.
- R6: `rd_en_i` high while `fill_o` is 0 has no effect.
- R7: A word completed while `fill_o` equals DEPTH is dropped, even if a read happens on the same edge. The words already stored are unchanged.
- R8: `overflow_o` goes to 1 on the edge where a word is dropped. It then stays at 1 until reset.
- R9: `frame_start_o` is high for exactly one cycle, after the first edge at which `vsync_i` is sampled high following a sample of low. The sample taken during reset counts as low.
- R10: A write and a read on the same edge, when the FIFO is neither empty nor full, leave `fill_o` unchanged and keep the order of the words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock; also clocks the FIFO read side |
| rst | input | 1 | Synchronous active-high reset |
| cam_data_i | input | 8 | Camera byte bus |
| line_valid_i | input | 1 | Line strobe; bytes are captured while it is high |
| vsync_i | input | 1 | Frame strobe, active high |
| rd_en_i | input | 1 | Pops the oldest word |
| rd_data_o | output | 16 | Oldest stored word (falls through) |
| fill_o | output | $clog2(DEPTH)+1 | Number of stored words |
| frame_start_o | output | 1 | One-cycle pulse on a rising frame strobe |
| overflow_o | output | 1 | Sticky flag: a word was dropped |

## Verification
The assertions take two things for granted. The first is that DEPTH is a power of two, so the pointers wrap naturally. The second is that reset is held for at least one edge, which puts the phase flag and the previous frame-strobe sample in known states. Inputs change only between clock edges. Reads may be requested at any time, including when the FIFO is empty, and the full and empty guards inside the FIFO are what the assertions check. The random stimulus is built from bursts of line-valid cycles with gaps of uneven length, so it produces odd-length lines, repeated overflow and rare frame strobes. The directed cases drive the full and empty limits exactly.

// File: rtl/cpk_pkg.sv
package cpk_pkg;

    typedef logic [7:0]  byte_t;
    typedef logic [15:0] word_t;

    // Phase of the byte pair: upper half expected next, or lower half expected next
    typedef enum logic {
        PH_UPPER = 1'b0,
        PH_LOWER = 1'b1
    } pair_phase_e;

    function automatic word_t join_bytes(input byte_t upper, input byte_t lower);
        return {upper, lower};
    endfunction

endpackage

// File: rtl/cpk_pair_builder.sv
module cpk_pair_builder
    import cpk_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  line_valid_i,
    input  byte_t byte_i,
    output logic  push_o,
    output word_t word_o
);

    pair_phase_e phase_q;
    byte_t       upper_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_UPPER;
            upper_q <= '0;
        end else if (!line_valid_i) begin
            phase_q <= PH_UPPER;
        end else if (phase_q == PH_UPPER) begin
            upper_q <= byte_i;
            phase_q <= PH_LOWER;
        end else begin
            phase_q <= PH_UPPER;
        end
    end

    // The flag phase itself is the write strobe
    assign push_o = line_valid_i && (phase_q == PH_LOWER);
    assign word_o = join_bytes(upper_q, byte_i);

    // R2: the first byte of a pair is latched as the upper half and the phase flips
    a_r2_upper_latch: assert property (@(posedge clk) disable iff (rst)
        (line_valid_i && phase_q == PH_UPPER) |=> (phase_q == PH_LOWER && upper_q == $past(byte_i)));

    // R4: a low line strobe restarts the pairing
    a_r4_line_restart: assert property (@(posedge clk) disable iff (rst)
        !line_valid_i |=> phase_q == PH_UPPER);

endmodule

// File: rtl/cpk_word_fifo.sv
module cpk_word_fifo
    import cpk_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_i,
    input  word_t                    wr_data_i,
    input  logic                     rd_i,
    output word_t                    rd_data_o,
    output logic [$clog2(DEPTH):0]   fill_o,
    output logic                     overflow_o
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    word_t           mem [DEPTH];
    logic [AW-1:0]   wptr_q, rptr_q;
    logic [CW-1:0]   cnt_q;
    logic            ovf_q;
    logic            full, empty, do_wr, do_rd;

    assign full  = (cnt_q == CW'(DEPTH));
    assign empty = (cnt_q == '0);
    assign do_wr = wr_i && !full;
    assign do_rd = rd_i && !empty;

    always_ff @(posedge clk) begin
        if (do_wr) mem[wptr_q] <= wr_data_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
            ovf_q  <= 1'b0;
        end else begin
            if (do_wr) wptr_q <= wptr_q + 1'b1;
            if (do_rd) rptr_q <= rptr_q + 1'b1;
            case ({do_wr, do_rd})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
            if (wr_i && full) ovf_q <= 1'b1;
        end
    end

    assign rd_data_o  = mem[rptr_q];
    assign fill_o     = cnt_q;
    assign overflow_o = ovf_q;

    // R5: the count never exceeds the capacity
    a_r5_fill_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(DEPTH));

    // R6: a read on an empty FIFO leaves it empty
    a_r6_empty_read: assert property (@(posedge clk) disable iff (rst)
        (empty && rd_i && !wr_i) |=> cnt_q == '0);

    // R7: a push while full with no read leaves the count as it was
    a_r7_drop_full: assert property (@(posedge clk) disable iff (rst)
        (full && wr_i && !rd_i) |=> cnt_q == $past(cnt_q));

    // R8: the overflow flag holds once set
    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
        ovf_q |=> ovf_q);

    // R10: a push and a pop together keep the count
    a_r10_balanced: assert property (@(posedge clk) disable iff (rst)
        (!full && !empty && wr_i && rd_i) |=> cnt_q == $past(cnt_q));

endmodule

// File: rtl/cpk_frame_edge.sv
module cpk_frame_edge (
    input  logic clk,
    input  logic rst,
    input  logic vsync_i,
    output logic start_o
);

    logic prev_q, pulse_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            prev_q  <= vsync_i;
            pulse_q <= vsync_i && !prev_q;
        end
    end

    assign start_o = pulse_q;

    // R9: the frame start is a single-cycle pulse
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
        pulse_q |=> !pulse_q);

endmodule

// File: rtl/cam_byte_packer.sv
module cam_byte_packer
    import cpk_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [7:0]             cam_data_i,
    input  logic                   line_valid_i,
    input  logic                   vsync_i,
    input  logic                   rd_en_i,
    output logic [15:0]            rd_data_o,
    output logic [$clog2(DEPTH):0] fill_o,
    output logic                   frame_start_o,
    output logic                   overflow_o
);

    logic  push;
    word_t word;

    cpk_pair_builder i_pair (
        .clk          (clk),
        .rst          (rst),
        .line_valid_i (line_valid_i),
        .byte_i       (cam_data_i),
        .push_o       (push),
        .word_o       (word)
    );

    cpk_word_fifo #(.DEPTH(DEPTH)) i_fifo (
        .clk        (clk),
        .rst        (rst),
        .wr_i       (push),
        .wr_data_i  (word),
        .rd_i       (rd_en_i),
        .rd_data_o  (rd_data_o),
        .fill_o     (fill_o),
        .overflow_o (overflow_o)
    );

    cpk_frame_edge i_frame (
        .clk     (clk),
        .rst     (rst),
        .vsync_i (vsync_i),
        .start_o (frame_start_o)
    );

    // R1: the reset state is clear on the first cycle after reset
    a_r1_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> (fill_o == '0 && !overflow_o && !frame_start_o));

endmodule

// File: tb/test_cam_byte_packer.sv
module test_cam_byte_packer;

    localparam int DEPTH = 8;
    localparam int FW    = $clog2(DEPTH) + 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [7:0]    cam_data = '0;
    logic          line_valid = 1'b0;
    logic          vsync = 1'b0;
    logic          rd_en = 1'b0;
    logic [15:0]   rd_data;
    logic [FW-1:0] fill;
    logic          frame_start;
    logic          overflow;

    int checks = 0;
    int errors = 0;
    string tag = "R1";

    // Bench model of the block, kept from the requirements
    logic [15:0] q[$];
    bit          m_phase = 0;
    logic [7:0]  m_upper = '0;
    bit          m_ovf = 0;
    bit          m_vprev = 0;
    bit          m_fs = 0;

    always #10 clk = ~clk;

    cam_byte_packer #(.DEPTH(DEPTH)) i_cam_byte_packer (
        .clk           (clk),
        .rst           (rst),
        .cam_data_i    (cam_data),
        .line_valid_i  (line_valid),
        .vsync_i       (vsync),
        .rd_en_i       (rd_en),
        .rd_data_o     (rd_data),
        .fill_o        (fill),
        .frame_start_o (frame_start),
        .overflow_o    (overflow)
    );

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] pair_word(input logic [7:0] u, input logic [7:0] l);
        return {u, l};
    endfunction

    task automatic compare_outputs();
        chk("fill", int'(fill), q.size());
        chk("overflow", int'(overflow), int'(m_ovf));
        chk("frame_start", int'(frame_start), int'(m_fs));
        if (q.size() > 0) chk("rd_data", int'(rd_data), int'(q[0]));
    endtask

    // Called at a negedge: drive inputs, compare, let one edge pass, update the model
    task automatic step(input bit lv, input logic [7:0] d, input bit vs, input bit rd);
        bit full, empty;
        line_valid = lv; cam_data = d; vsync = vs; rd_en = rd;
        #1;
        compare_outputs();
        @(posedge clk);
        full  = (q.size() == DEPTH);
        empty = (q.size() == 0);
        if (rd && !empty) void'(q.pop_front());
        if (lv && m_phase) begin
            if (!full) q.push_back(pair_word(m_upper, d));
            else m_ovf = 1;
        end
        if (lv) begin
            if (!m_phase) m_upper = d;
            m_phase = !m_phase;
        end else begin
            m_phase = 0;
        end
        m_fs = vs && !m_vprev;
        m_vprev = vs;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        // R1: reset state
        tag = "R1";
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare_outputs();
        rst = 1'b0;
        step(0, 8'h00, 0, 0);

        // R2: pairing order and write timing
        tag = "R2";
        step(1, 8'h12, 0, 0);
        step(1, 8'h34, 0, 0);
        step(1, 8'h56, 0, 0);
        step(1, 8'h78, 0, 0);
        step(0, 8'h00, 0, 0);
        chk("first word", int'(rd_data), 16'h1234);

        // R3: bytes outside the line strobe are ignored
        tag = "R3";
        for (int i = 0; i < 5; i++) step(0, 8'($urandom), 0, 0);
        chk("fill idle", int'(fill), 2);

        // R4: odd byte at end of line is discarded
        tag = "R4";
        step(1, 8'hA1, 0, 0);
        step(1, 8'hA2, 0, 0);
        step(1, 8'hA3, 0, 0);
        step(0, 8'hFF, 0, 0);
        step(1, 8'hB1, 0, 0);
        step(1, 8'hB2, 0, 0);
        step(0, 8'h00, 0, 0);

        // R5: order of reads
        tag = "R5";
        chk("head", int'(rd_data), 16'h1234);
        step(0, 8'h00, 0, 1);
        chk("second", int'(rd_data), 16'h5678);
        step(0, 8'h00, 0, 1);
        chk("third", int'(rd_data), 16'hA1A2);
        step(0, 8'h00, 0, 1);
        chk("fourth", int'(rd_data), 16'hB1B2);
        step(0, 8'h00, 0, 1);

        // R6: read while empty
        tag = "R6";
        step(0, 8'h00, 0, 1);
        step(0, 8'h00, 0, 1);
        chk("fill empty", int'(fill), 0);

        // R10: simultaneous push and pop
        tag = "R10";
        for (int i = 0; i < 6; i++) step(1, 8'(8'h20 + i), 0, 0);
        for (int i = 0; i < 6; i++) step(1, 8'(8'h40 + i), 0, i[0]);
        step(0, 8'h00, 0, 0);

        // R7: fill to the limit, then push into a full FIFO
        tag = "R7";
        for (int i = 0; i < 2 * DEPTH; i++) step(1, 8'(8'h60 + i), 0, 0);
        step(0, 8'h00, 0, 0);
        chk("fill full", int'(fill), DEPTH);
        step(1, 8'hC0, 0, 1);
        step(1, 8'hC1, 0, 1);
        step(0, 8'h00, 0, 0);

        // R8: overflow stays set after draining
        tag = "R8";
        for (int i = 0; i < DEPTH + 2; i++) step(0, 8'h00, 0, 1);
        chk("overflow sticky", int'(overflow), 1);

        // R9: frame strobe edges
        tag = "R9";
        step(0, 8'h00, 1, 0);
        step(0, 8'h00, 1, 0);
        step(0, 8'h00, 1, 0);
        step(0, 8'h00, 0, 0);
        step(0, 8'h00, 1, 0);
        step(0, 8'h00, 0, 0);

        // R2: random mixed traffic
        tag = "R2";
        for (int i = 0; i < 3000; i++)
            step(($urandom % 5) != 0, 8'($urandom), ($urandom % 40) == 0, ($urandom % 3) == 0);
        step(0, 8'h00, 0, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule